// File: doc/BRIEF.md
# Dual-Mode Interval Timer with Toggle

This block is a 16-bit down-counting interval timer that sits behind an 8-bit register bus with a 4-bit register select. The block holds a counter and a separate reload latch, and each of them is reachable as a low byte and a high byte. Once software starts it, the counter drops by one on every clock. When it passes zero the timer raises a timeout flag. It can also drive a general-purpose output pin, either inverting that pin on every period or returning it high after a single shot.

Software loads the low latch byte first. Writing the counter high byte then starts a run with the 16-bit value made of the written byte and the low latch byte. A mode bit in the control register chooses how the timer behaves after a timeout. In free-running mode it reloads from the latch and the pin inverts on each timeout. In one-shot mode the counter keeps counting down through a wrap, but the flag rises only once for each start. Reading the counter low byte acknowledges the flag.

Top module: `ivt_top`

## Requirements
- R1: After reset the counter and both latch bytes read 0, the control register reads 0, the flag is low and the pin is high. The counter holds its value until the first start.
- R2: A write to select 5 copies the written byte into the high latch byte and loads the counter with {written byte, low latch byte} on that clock edge. The same edge clears the flag, drives the pin low and starts counting. If a timeout falls on that edge, the start takes priority over it.
- R3: While the timer runs, the counter drops by one on every clock edge that is neither a start nor a free-run reload. A write to select 4 changes only the low latch byte, which reads back at select 6.
- R4: After a start with value N, the first timeout comes on the (N+1)th clock edge. That timeout sets the flag, which appears on the flag output and as bit 6 of select 13.
- R5: The flag is cleared on the edge of a read of select 4, and also on the edge of a write to select 13 with bit 6 set. A timeout on that same edge sets the flag instead.
- R6: With control bit 6 set to 1 (free-running), each timeout reloads the counter from the latch and inverts the pin. The period is therefore latch value + 1 cycles.
- R7: With control bit 6 set to 0 (one-shot), the first timeout after a start sets the flag and drives the pin high. The counter then wraps to 0xFFFF and keeps counting, and later zero crossings set neither the flag nor the pin.
- R8: Writes to select 6 and select 7 change only the latch bytes and never the running count. The next free-run reload uses the new latch value.
- R9: The control register sits at select 11 and reads back as written. The pin output-enable follows control bit 7.
- R10: Select 5 reads the counter high byte and select 7 reads the high latch byte. Selects that hold no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 4 | Register select |
| wr_en_i | input | 1 | Write strobe for the current clock |
| rd_en_i | input | 1 | Read strobe (side effects only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for sel_i, combinational |
| irq_flag_o | output | 1 | Timeout flag |
| tgl_pin_o | output | 1 | Timer-driven pin value |
| tgl_pin_oe_o | output | 1 | Pin output enable (control bit 7) |

## Verification
On every cycle the assertions check how the counter steps. A start loads {data, low latch}, a running counter drops by one, and a stopped counter holds. They also check that the flag rises only on a qualified timeout, that a start clears the flag and the pin, and that a free-run timeout both reloads and inverts the pin. Some behaviours only the bench scenarios can show: the exact N+1 latency, the once-per-start rule of one-shot mode across a full 65536-cycle wrap, which side wins when a read clear meets a timeout on the same edge, and the fact that latch writes leave the visible count alone.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 4;

  localparam logic [SEL_W-1:0] SEL_CNT_LO = 4'd4;
  localparam logic [SEL_W-1:0] SEL_CNT_HI = 4'd5;
  localparam logic [SEL_W-1:0] SEL_LAT_LO = 4'd6;
  localparam logic [SEL_W-1:0] SEL_LAT_HI = 4'd7;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 4'd11;
  localparam logic [SEL_W-1:0] SEL_FLAGS  = 4'd13;

  localparam int unsigned CTRL_FREE_BIT = 6;
  localparam int unsigned CTRL_PIN_BIT  = 7;
  localparam int unsigned FLAG_BIT      = 6;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned BW = ivt_pkg::BYTE_W,
  parameter int unsigned SW = ivt_pkg::SEL_W,
  localparam int unsigned CW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          flag_i,
  output logic [BW-1:0] rdata_o,
  output logic [CW-1:0] latch_o,
  output logic [CW-1:0] load_o,
  output logic [BW-1:0] ctrl_o,
  output logic          start_o,
  output logic          rd_clr_o,
  output logic          wr_clr_o
);
  logic [BW-1:0] lat_lo_q, lat_hi_q, ctrl_q;

  wire hit_cnt_lo = (sel_i == SW'(SEL_CNT_LO));
  wire hit_cnt_hi = (sel_i == SW'(SEL_CNT_HI));
  wire hit_lat_lo = (sel_i == SW'(SEL_LAT_LO));
  wire hit_lat_hi = (sel_i == SW'(SEL_LAT_HI));
  wire hit_ctrl   = (sel_i == SW'(SEL_CTRL));
  wire hit_flags  = (sel_i == SW'(SEL_FLAGS));

  // Both counter-low and latch-low writes land in the low latch byte.
  wire lo_wr = wr_en_i && (hit_cnt_lo || hit_lat_lo);
  wire hi_wr = wr_en_i && (hit_cnt_hi || hit_lat_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_lo_q <= '0;
      lat_hi_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (lo_wr) lat_lo_q <= wdata_i;
      if (hi_wr) lat_hi_q <= wdata_i;
      if (wr_en_i && hit_ctrl) ctrl_q <= wdata_i;
    end
  end

  function automatic logic [BW-1:0] read_mux(
    input logic [SW-1:0] s, input logic [CW-1:0] cnt,
    input logic [BW-1:0] llo, input logic [BW-1:0] lhi,
    input logic [BW-1:0] ctl, input logic flg);
    logic [BW-1:0] fv;
    fv = '0;
    fv[FLAG_BIT] = flg;
    case (s)
      SW'(SEL_CNT_LO): return cnt[BW-1:0];
      SW'(SEL_CNT_HI): return cnt[CW-1:BW];
      SW'(SEL_LAT_LO): return llo;
      SW'(SEL_LAT_HI): return lhi;
      SW'(SEL_CTRL):   return ctl;
      SW'(SEL_FLAGS):  return fv;
      default:         return '0;
    endcase
  endfunction

  assign rdata_o  = read_mux(sel_i, cnt_i, lat_lo_q, lat_hi_q, ctrl_q, flag_i);
  assign latch_o  = {lat_hi_q, lat_lo_q};
  assign load_o   = {wdata_i, lat_lo_q};
  assign ctrl_o   = ctrl_q;
  assign start_o  = wr_en_i && hit_cnt_hi;
  assign rd_clr_o = rd_en_i && hit_cnt_lo;
  assign wr_clr_o = wr_en_i && hit_flags && wdata_i[FLAG_BIT];
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] load_i,
  input  logic [CW-1:0] reload_i,
  input  logic          free_i,
  output logic [CW-1:0] cnt_o,
  output logic          timeout_o,
  output logic          running_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  function automatic logic [CW-1:0] step_count(
    input logic [CW-1:0] cur, input logic [CW-1:0] rel,
    input logic hit, input logic fre);
    if (hit && fre) return rel;
    return cur - CW'(1);
  endfunction

  // A start on the same edge masks a zero crossing.
  assign timeout_o = run_q && (cnt_q == '0) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= load_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= step_count(cnt_q, reload_i, timeout_o, free_i);
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;
endmodule

// File: rtl/ivt_event.sv
module ivt_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic timeout_i,
  input  logic free_i,
  input  logic rd_clr_i,
  input  logic wr_clr_i,
  output logic fire_o,
  output logic flag_o,
  output logic pin_o
);
  logic armed_q, flag_q, pin_q;

  // Free-run fires on every timeout, one-shot only while armed.
  assign fire_o = timeout_i && (free_i || armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      pin_q   <= 1'b1;
    end else if (start_i) begin
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (timeout_i && !free_i) armed_q <= 1'b0;
      if (fire_o)                     flag_q <= 1'b1;
      else if (rd_clr_i || wr_clr_i)  flag_q <= 1'b0;
      if (fire_o) pin_q <= free_i ? !pin_q : 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = ivt_pkg::BYTE_W,
  parameter int unsigned SELW   = ivt_pkg::SEL_W,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SELW-1:0]   sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_flag_o,
  output logic              tgl_pin_o,
  output logic              tgl_pin_oe_o
);
  logic [CNT_W-1:0]  cnt_w, latch_w, load_w;
  logic [DATA_W-1:0] ctrl_w;
  logic start_w, rd_clr_w, wr_clr_w, timeout_w, running_w, fire_w;
  logic flag_w, pin_w, free_w;

  ivt_regs #(.BW(DATA_W), .SW(SELW)) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_en_i, .rd_en_i, .wdata_i,
    .cnt_i(cnt_w), .flag_i(flag_w), .rdata_o,
    .latch_o(latch_w), .load_o(load_w), .ctrl_o(ctrl_w),
    .start_o(start_w), .rd_clr_o(rd_clr_w), .wr_clr_o(wr_clr_w)
  );

  assign free_w = ctrl_w[CTRL_FREE_BIT];

  ivt_count #(.CW(CNT_W)) u_count (
    .clk_i, .rst_ni, .start_i(start_w), .load_i(load_w),
    .reload_i(latch_w), .free_i(free_w), .cnt_o(cnt_w),
    .timeout_o(timeout_w), .running_o(running_w)
  );

  ivt_event u_event (
    .clk_i, .rst_ni, .start_i(start_w), .timeout_i(timeout_w),
    .free_i(free_w), .rd_clr_i(rd_clr_w), .wr_clr_i(wr_clr_w),
    .fire_o(fire_w), .flag_o(flag_w), .pin_o(pin_w)
  );

  assign irq_flag_o   = flag_w;
  assign tgl_pin_o    = pin_w;
  assign tgl_pin_oe_o = ctrl_w[CTRL_PIN_BIT];
endmodule

// File: rtl/ivt_top_chk.sv
module ivt_top_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SELW   = 4,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SELW-1:0]   sel_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  latch_w,
  input logic              start_w,
  input logic              timeout_w,
  input logic              running_w,
  input logic              fire_w,
  input logic              free_w,
  input logic              flag_w,
  input logic              pin_w
);
  a_r1_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_w && !start_w) |=> $stable(cnt_w));

  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (cnt_w == {$past(wdata_i), $past(latch_w[DATA_W-1:0])}));

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (!flag_w && !pin_w));

  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_w && !start_w && !timeout_w) |=> (cnt_w == $past(cnt_w) - CNT_W'(1)));

  a_r4_fire_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_w |=> flag_w);

  a_r4_flag_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_w) |-> $past(fire_w));

  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_i == SELW'(4) && !fire_w) |=> !flag_w);

  a_r6_free_reload_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_w && free_w) |=> (pin_w != $past(pin_w)) && (cnt_w == $past(latch_w)));

  a_r7_oneshot_pin_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_w && !free_w) |=> pin_w);
endmodule

bind ivt_top ivt_top_chk #(.DATA_W(DATA_W), .SELW(SELW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .rd_en_i(rd_en_i),
  .wdata_i(wdata_i), .cnt_w(cnt_w), .latch_w(latch_w), .start_w(start_w),
  .timeout_w(timeout_w), .running_w(running_w), .fire_w(fire_w),
  .free_w(free_w), .flag_w(flag_w), .pin_w(pin_w)
);

// File: tb/ivt_top_tb_top.sv
`timescale 1ns/1ps
module ivt_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sel_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_flag_o, tgl_pin_o, tgl_pin_oe_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ivt_top dut_i (.*);

  function automatic logic [15:0] exp_count(input logic [15:0] n, input int j);
    return n - 16'(j);
  endfunction

  function automatic logic [15:0] exp_after_timeout(input bit free, input logic [15:0] n);
    return free ? n : 16'hFFFF;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    sel_i = s; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_ack();
    sel_i = 4'd4; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic peek(input logic [3:0] s, output logic [7:0] d);
    sel_i = s;
    #1 d = rdata_o;
  endtask

  task automatic peek_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    peek(4'd4, lo);
    peek(4'd5, hi);
    c = {hi, lo};
  endtask

  initial begin
    logic [7:0]  d;
    logic [15:0] c;
    void'($urandom(32'd7));
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state and stopped counter
    check("R1 flag", 16'(irq_flag_o), 16'd0);
    check("R1 pin", 16'(tgl_pin_o), 16'd1);
    check("R1 oe", 16'(tgl_pin_oe_o), 16'd0);
    peek(4'd6, d); check("R1 latch lo", 16'(d), 16'd0);
    peek(4'd7, d); check("R1 latch hi", 16'(d), 16'd0);
    peek(4'd11, d); check("R1 ctrl", 16'(d), 16'd0);
    idle(5);
    peek_cnt(c); check("R1 counter held", c, 16'd0);

    // R9 control register
    wr(4'd11, 8'hC0);
    peek(4'd11, d); check("R9 ctrl readback", 16'(d), 16'h00C0);
    check("R9 oe", 16'(tgl_pin_oe_o), 16'd1);

    // R3 low write only touches latch
    wr(4'd4, 8'h05);
    peek(4'd6, d); check("R3 latch lo", 16'(d), 16'h0005);
    peek_cnt(c); check("R3 counter untouched", c, 16'd0);

    // R2 start
    wr(4'd5, 8'h00);
    peek_cnt(c); check("R2 load", c, 16'h0005);
    peek(4'd7, d); check("R10 latch hi", 16'(d), 16'd0);
    check("R2 pin low", 16'(tgl_pin_o), 16'd0);
    check("R2 flag clear", 16'(irq_flag_o), 16'd0);
    idle(2);
    peek_cnt(c); check("R3 decrement", c, exp_count(16'd5, 2));
    idle(3);
    check("R4 no flag before N+1", 16'(irq_flag_o), 16'd0);
    idle(1);
    check("R4 flag at N+1", 16'(irq_flag_o), 16'd1);
    peek(4'd13, d); check("R4 flag reg bit6", 16'(d), 16'h0040);
    peek_cnt(c); check("R6 reload", c, 16'd5);
    check("R6 pin toggled", 16'(tgl_pin_o), 16'd1);
    idle(5);
    check("R6 pin before 2nd", 16'(tgl_pin_o), 16'd1);
    idle(1);
    check("R6 pin after 2nd", 16'(tgl_pin_o), 16'd0);

    // R5 clears
    rd_ack();
    check("R5 read clear", 16'(irq_flag_o), 16'd0);
    idle(5);
    check("R5 refire", 16'(irq_flag_o), 16'd1);
    wr(4'd13, 8'h40);
    check("R5 write clear", 16'(irq_flag_o), 16'd0);
    idle(4);
    rd_ack();
    check("R5 set wins", 16'(irq_flag_o), 16'd1);

    // R8 latch writes during run
    wr(4'd6, 8'h02);
    peek_cnt(c); check("R8 lat lo no disturb", c, 16'd4);
    wr(4'd7, 8'h00);
    peek_cnt(c); check("R8 lat hi no disturb", c, 16'd3);
    idle(4);
    peek_cnt(c); check("R8 new reload", c, 16'd2);

    // R7 one-shot
    wr(4'd11, 8'h80);
    wr(4'd4, 8'h03);
    wr(4'd5, 8'h00);
    peek_cnt(c); check("R2 start over timeout", c, 16'd3);
    idle(3);
    check("R7 flag not yet", 16'(irq_flag_o), 16'd0);
    check("R7 pin low", 16'(tgl_pin_o), 16'd0);
    idle(1);
    check("R7 flag", 16'(irq_flag_o), 16'd1);
    check("R7 pin high", 16'(tgl_pin_o), 16'd1);
    peek_cnt(c); check("R7 wrap", c, 16'hFFFF);
    rd_ack();
    idle(65534);
    peek_cnt(c); check("R7 reaches zero", c, 16'd0);
    idle(1);
    check("R7 no second flag", 16'(irq_flag_o), 16'd0);
    check("R7 pin stays", 16'(tgl_pin_o), 16'd1);

    // R10 unused selects
    peek(4'd0, d); check("R10 sel0", 16'(d), 16'd0);
    peek(4'd15, d); check("R10 sel15", 16'(d), 16'd0);

    // random runs
    for (int it = 0; it < 40; it++) begin
      logic [7:0] lo;
      bit free, oe;
      int j;
      lo = 8'($urandom_range(0, 60));
      free = bit'($urandom_range(0, 1));
      oe = bit'($urandom_range(0, 1));
      wr(4'd11, {oe, free, 6'b0});
      check("R9 oe random", 16'(tgl_pin_oe_o), 16'(oe));
      wr(4'd4, lo);
      wr(4'd5, 8'h00);
      j = $urandom_range(0, int'(lo));
      idle(j);
      peek_cnt(c); check("R3 random count", c, exp_count(16'(lo), j));
      idle(int'(lo) - j);
      check("R4 random early", 16'(irq_flag_o), 16'd0);
      idle(1);
      check("R4 random flag", 16'(irq_flag_o), 16'd1);
      check("R6/R7 random pin", 16'(tgl_pin_o), 16'd1);
      peek_cnt(c); check("R6/R7 random after", c, exp_after_timeout(free, 16'(lo)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule